// File: doc/BRIEF.md
# Multi-rate transceiver rate-change sequencer

This controller sits on the host side of a serial transceiver subsystem made of several duals, each able to run at one of several line rates. It owns the control pins of that subsystem. After a system reset it pulses the subsystem reset and waits for the subsystem's 2-bit status word to report that reset is complete. It can then run an RX reset and calibration step for the duals that start at PAM4 rates.

In idle it accepts a rate command. It drives the per-dual target rates, raises the rate-change request and drops it once the subsystem acknowledges. It then waits until the reported per-dual rates equal the targets. After the change it either calibrates the PAM4 duals itself or arms the subsystem's automatic reset requests and calibrates the duals that raise them.

A timeout guards every wait. When it expires, the controller parks in an error state that only a system reset clears. A busy flag and a one-cycle completion pulse frame each operation.

Top module: `rate_seq`

## Requirements
- R1: While `rst_n` is low, and for RST_HOLD cycles after it rises, `xcvr_reset_all` is 1. Bring-up then completes only when `sys_stat` reads 0 in one cycle and 1 in the next. A status of 1 with no 0 before it is not accepted.
- R2: At bring-up completion, a nonzero `boot_cal_mask` starts calibration of those duals. This boot calibration ends when `sys_stat` reads 3. A zero mask returns the controller straight to idle.
- R3: During a calibration step, `xcvr_cal_en` carries the selected duals. It is set at least one cycle before `xcvr_rx_rst` rises and stays set until the step ends. `xcvr_rx_rst` is never high while `xcvr_cal_en` is zero.
- R4: After a rate change, `xcvr_rx_rst` rises only in the cycle after `sys_stat` reads 3. It falls in the cycle after `sys_stat` goes from 3 to 1. Calibration ends when `sys_stat` next reads 3.
- R5: A `cmd_valid` seen in idle is accepted. In the next cycle `xcvr_rate_tgt` equals `cmd_rate`, with dual d at bits [d*RATE_W +: RATE_W], and `xcvr_rate_req` is 1.
- R6: `xcvr_rate_req` stays high while every bit of `xcvr_rate_done` is 1. It is low in the cycle after any bit reads 0.
- R7: The change completes when `xcvr_rate_stat` equals `xcvr_rate_tgt`. With automatic reset off, calibration then runs on the duals in `cmd_pam4`, or the controller returns to idle when that mask is 0.
- R8: `xcvr_auto_en` equals `cmd_auto` masked to the duals whose command rate differs from `xcvr_rate_stat` at accept. No default rate is assumed after reset. It is held from the request until the reset requests arrive.
- R9: With a nonzero `xcvr_auto_en`, the controller waits for `xcvr_auto_req`. It then calibrates exactly the requesting duals within `xcvr_auto_en`. Request bits outside that mask are ignored.
- R10: If any wait lasts TIMEOUT cycles, `err` goes to 1. The controller then holds busy, request, RX reset and calibration enable low and ignores commands. Only `rst_n` clears `err`.
- R11: `busy` is 1 from reset or command accept until the operation ends. `done` is a single-cycle pulse in the first idle cycle after it ends.
- R12: A `cmd_valid` seen while busy is ignored. The target is unchanged and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| boot_cal_mask | input | NDUAL | Duals to calibrate after bring-up |
| cmd_valid | input | 1 | Rate command strobe |
| cmd_rate | input | NDUAL*RATE_W | Per-dual target rate of the command |
| cmd_auto | input | NDUAL | Per-dual automatic RX reset request |
| cmd_pam4 | input | NDUAL | Duals to calibrate after the change when automatic reset is off |
| sys_stat | input | 2 | Subsystem status word |
| xcvr_rate_done | input | NDUAL | Per-dual rate-change done vector |
| xcvr_rate_stat | input | NDUAL*RATE_W | Per-dual reported rate |
| xcvr_auto_req | input | NDUAL | Per-dual automatic reset request from the subsystem |
| xcvr_reset_all | output | 1 | Full subsystem reset |
| xcvr_rx_rst | output | 1 | RX datapath reset |
| xcvr_cal_en | output | NDUAL | Per-dual calibration enable |
| xcvr_rate_req | output | 1 | Rate-change enable |
| xcvr_rate_tgt | output | NDUAL*RATE_W | Per-dual target rate |
| xcvr_auto_en | output | NDUAL | Per-dual automatic RX reset enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout error |

## Verification
The bench starts from a subsystem that already reports non-default rates and a stale status of 1. A design that accepted a lone 1 as reset done would finish bring-up early. A design that assumed default rates would arm automatic reset on a dual that is not changing. Calibration after a change is driven through the full 3, 1, 3 status sequence. This catches an RX reset raised before status 3, or one released too early or too late. Automatic reset requests on duals outside the armed mask would show up as extra calibration enables. The bench also sends commands while busy and lets an acknowledge never arrive. These would expose a retargeted or queued request, and an error that clears itself or lets the request keep running.

// File: rtl/rate_seq.sv
module rate_seq #(
  parameter int NDUAL    = 2,
  parameter int RATE_W   = 3,
  parameter int RST_HOLD = 4,
  parameter int TIMEOUT  = 4096
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NDUAL-1:0]        boot_cal_mask,
  input  logic                    cmd_valid,
  input  logic [NDUAL*RATE_W-1:0] cmd_rate,
  input  logic [NDUAL-1:0]        cmd_auto,
  input  logic [NDUAL-1:0]        cmd_pam4,
  input  logic [1:0]              sys_stat,
  input  logic [NDUAL-1:0]        xcvr_rate_done,
  input  logic [NDUAL*RATE_W-1:0] xcvr_rate_stat,
  input  logic [NDUAL-1:0]        xcvr_auto_req,
  output logic                    xcvr_reset_all,
  output logic                    xcvr_rx_rst,
  output logic [NDUAL-1:0]        xcvr_cal_en,
  output logic                    xcvr_rate_req,
  output logic [NDUAL*RATE_W-1:0] xcvr_rate_tgt,
  output logic [NDUAL-1:0]        xcvr_auto_en,
  output logic                    busy,
  output logic                    done,
  output logic                    err
);

  localparam int CNT_MAX = (TIMEOUT > RST_HOLD) ? TIMEOUT : RST_HOLD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [NDUAL-1:0] ALL1 = {NDUAL{1'b1}};

  typedef enum logic [3:0] {
    S_IDLE, S_RSTA, S_WRST, S_CARM, S_CRST, S_CWAIT,
    S_RREQ, S_RWAIT, S_RAUTO, S_ERR
  } state_t;

  state_t st, nxt;
  logic [CNT_W-1:0]        cnt;
  logic [1:0]              stat_q;
  logic                    is_rc;
  logic                    done_q;
  logic [NDUAL-1:0]        auto_q, pam_q, cal_q, chg;
  logic [NDUAL*RATE_W-1:0] tgt_q;
  logic                    waiting, expired;

  always_comb begin
    for (int d = 0; d < NDUAL; d++)
      chg[d] = cmd_rate[d*RATE_W +: RATE_W] != xcvr_rate_stat[d*RATE_W +: RATE_W];
  end

  assign waiting = (st != S_IDLE) && (st != S_RSTA) && (st != S_ERR);
  assign expired = waiting && (cnt == CNT_W'(TIMEOUT - 1));

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:  if (cmd_valid) nxt = S_RREQ;
      S_RSTA:  if (cnt == CNT_W'(RST_HOLD - 1)) nxt = S_WRST;
      S_WRST:  if (stat_q == 2'd0 && sys_stat == 2'd1)
                 nxt = (boot_cal_mask != '0) ? S_CARM : S_IDLE;
      S_CARM:  if (!is_rc || sys_stat == 2'd3) nxt = S_CRST;
      S_CRST:  if (is_rc) begin
                 if (stat_q == 2'd3 && sys_stat == 2'd1) nxt = S_CWAIT;
               end else if (sys_stat == 2'd3) nxt = S_IDLE;
      S_CWAIT: if (sys_stat == 2'd3) nxt = S_IDLE;
      S_RREQ:  if (xcvr_rate_done != ALL1) nxt = S_RWAIT;
      S_RWAIT: if (xcvr_rate_stat == tgt_q)
                 nxt = (auto_q != '0) ? S_RAUTO : ((pam_q != '0) ? S_CARM : S_IDLE);
      S_RAUTO: if ((xcvr_auto_req & auto_q) != '0) nxt = S_CARM;
      default: nxt = S_ERR;
    endcase
    if (expired && nxt == st) nxt = S_ERR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RSTA;
      cnt    <= '0;
      stat_q <= 2'd3;
      is_rc  <= 1'b0;
      done_q <= 1'b0;
      auto_q <= '0;
      pam_q  <= '0;
      cal_q  <= '0;
      tgt_q  <= '0;
    end else begin
      st     <= nxt;
      stat_q <= sys_stat;
      done_q <= (nxt == S_IDLE) && (st != S_IDLE);
      if (nxt != st) cnt <= '0;
      else if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      if (st == S_IDLE && cmd_valid) begin
        tgt_q  <= cmd_rate;
        auto_q <= cmd_auto & chg;
        pam_q  <= cmd_pam4;
        is_rc  <= 1'b1;
      end
      if (st == S_WRST && nxt == S_CARM) begin
        cal_q <= boot_cal_mask;
        is_rc <= 1'b0;
      end
      if (st == S_RWAIT && nxt == S_CARM) cal_q <= pam_q;
      if (st == S_RAUTO && nxt == S_CARM) cal_q <= xcvr_auto_req & auto_q;
    end
  end

  assign xcvr_reset_all = (st == S_RSTA);
  assign xcvr_rx_rst    = (st == S_CRST);
  assign xcvr_cal_en    = (st == S_CARM || st == S_CRST || st == S_CWAIT) ? cal_q : '0;
  assign xcvr_rate_req  = (st == S_RREQ);
  assign xcvr_rate_tgt  = tgt_q;
  assign xcvr_auto_en   = (st == S_RREQ || st == S_RWAIT || st == S_RAUTO) ? auto_q : '0;
  assign busy           = waiting || (st == S_RSTA);
  assign done           = done_q;
  assign err            = (st == S_ERR);

  AST_RXRST_HAS_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_rx_rst |-> (xcvr_cal_en != '0)); // R3

  AST_CAL_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xcvr_rx_rst) |-> ($past(xcvr_cal_en) != '0)); // R3

  AST_RC_RST_AT3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xcvr_rx_rst) && is_rc) |-> ($past(sys_stat) == 2'd3)); // R4

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_rate_req && xcvr_rate_done != ALL1) |=> !xcvr_rate_req); // R6

  AST_TGT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(xcvr_rate_tgt)); // R12

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R10

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !xcvr_rate_req && !xcvr_rx_rst && xcvr_cal_en == '0)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

endmodule

// File: tb/rate_seq_bench.sv
module rate_seq_bench;
  localparam int NDUAL = 2;
  localparam int RATE_W = 3;
  localparam int TMO = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NDUAL-1:0] boot_cal_mask, cmd_auto, cmd_pam4, xcvr_rate_done, xcvr_auto_req;
  logic cmd_valid;
  logic [5:0] cmd_rate, xcvr_rate_stat;
  logic [1:0] sys_stat;
  logic xcvr_reset_all, xcvr_rx_rst, xcvr_rate_req, busy, done, err;
  logic [NDUAL-1:0] xcvr_cal_en, xcvr_auto_en;
  logic [5:0] xcvr_rate_tgt;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  rate_seq #(.NDUAL(NDUAL), .RATE_W(RATE_W), .RST_HOLD(4), .TIMEOUT(TMO)) u_rate_seq (
    .clk(clk), .rst_n(rst_n), .boot_cal_mask(boot_cal_mask), .cmd_valid(cmd_valid),
    .cmd_rate(cmd_rate), .cmd_auto(cmd_auto), .cmd_pam4(cmd_pam4), .sys_stat(sys_stat),
    .xcvr_rate_done(xcvr_rate_done), .xcvr_rate_stat(xcvr_rate_stat),
    .xcvr_auto_req(xcvr_auto_req), .xcvr_reset_all(xcvr_reset_all),
    .xcvr_rx_rst(xcvr_rx_rst), .xcvr_cal_en(xcvr_cal_en), .xcvr_rate_req(xcvr_rate_req),
    .xcvr_rate_tgt(xcvr_rate_tgt), .xcvr_auto_en(xcvr_auto_en), .busy(busy),
    .done(done), .err(err));

  // fields: rate[13:8] auto[7:6] pam4[5:4] exp_auto[3:2] exp_cal[1:0]
  localparam logic [13:0] VEC [0:3] = '{
    {6'b101_100, 2'b11, 2'b00, 2'b01, 2'b01},
    {6'b001_100, 2'b00, 2'b10, 2'b00, 2'b10},
    {6'b011_110, 2'b00, 2'b00, 2'b00, 2'b00},
    {6'b111_000, 2'b11, 2'b00, 2'b11, 2'b11}
  };

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_change(input logic [13:0] v);
    logic [5:0] rate;
    logic [1:0] ea, ec;
    rate = v[13:8]; ea = v[3:2]; ec = v[1:0];
    cmd_valid = 1'b1; cmd_rate = rate; cmd_auto = v[7:6]; cmd_pam4 = v[5:4];
    step;
    cmd_valid = 1'b0;
    chk(xcvr_rate_req == 1'b1, "R5 req", 32'(xcvr_rate_req), 1);
    chk(xcvr_rate_tgt == rate, "R5 tgt", 32'(xcvr_rate_tgt), 32'(rate));
    chk(xcvr_auto_en == ea, "R8 auto_en", 32'(xcvr_auto_en), 32'(ea));
    chk(busy == 1'b1, "R11 busy", 32'(busy), 1);
    step;
    chk(xcvr_rate_req == 1'b1, "R6 hold", 32'(xcvr_rate_req), 1);
    xcvr_rate_done = 2'b01;
    step;
    chk(xcvr_rate_req == 1'b0, "R6 drop", 32'(xcvr_rate_req), 0);
    xcvr_rate_done = 2'b11;
    sys_stat = 2'd1;
    step;
    chk(busy && xcvr_cal_en == 2'b00, "R7 wait", {busy, 30'd0, xcvr_cal_en}, 32'h8000_0000);
    xcvr_rate_stat = rate;
    step;
    if (ea != 2'b00) begin
      chk(xcvr_cal_en == 2'b00 && xcvr_auto_en == ea, "R9 arm", {xcvr_cal_en, xcvr_auto_en}, {ea});
      xcvr_auto_req = 2'b11;
      step;
      xcvr_auto_req = 2'b00;
      chk(xcvr_cal_en == ec, "R9 cal", 32'(xcvr_cal_en), 32'(ec));
    end else if (ec != 2'b00) begin
      chk(xcvr_cal_en == ec, "R7 cal", 32'(xcvr_cal_en), 32'(ec));
    end else begin
      chk(done && !busy, "R7 done", {done, busy}, 2'b10);
      step;
      return;
    end
    chk(xcvr_rx_rst == 1'b0, "R3 arm", 32'(xcvr_rx_rst), 0);
    step;
    chk(xcvr_rx_rst == 1'b0, "R4 wait3", 32'(xcvr_rx_rst), 0);
    sys_stat = 2'd3;
    step;
    chk(xcvr_rx_rst == 1'b1, "R4 rise", 32'(xcvr_rx_rst), 1);
    step;
    chk(xcvr_rx_rst == 1'b1, "R4 hold", 32'(xcvr_rx_rst), 1);
    sys_stat = 2'd1;
    step;
    chk(xcvr_rx_rst == 1'b0 && xcvr_cal_en == ec, "R4 fall", {xcvr_rx_rst, xcvr_cal_en}, {1'b0, ec});
    sys_stat = 2'd3;
    step;
    chk(done && !busy && xcvr_cal_en == 2'b00, "R11 done", {done, busy, xcvr_cal_en}, 4'b1000);
    step;
    chk(done == 1'b0, "R11 pulse", 32'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run;
  end

  initial begin
    rst_n = 1'b0; boot_cal_mask = 2'b01; cmd_valid = 1'b0; cmd_rate = '0;
    cmd_auto = '0; cmd_pam4 = '0; sys_stat = 2'd1; xcvr_rate_done = 2'b11;
    xcvr_rate_stat = {3'd5, 3'd2}; xcvr_auto_req = '0;
    repeat (3) @(negedge clk);
    chk(xcvr_reset_all && busy && !err && !done && !xcvr_rate_req, "R1 reset state",
        {xcvr_reset_all, busy, err, done, xcvr_rate_req}, 5'b11000);
    rst_n = 1'b1;
    repeat (8) step;
    chk(!xcvr_reset_all && busy && xcvr_cal_en == 2'b00, "R1 stale one",
        {xcvr_reset_all, busy, xcvr_cal_en}, 4'b0100);
    sys_stat = 2'd0;
    step;
    sys_stat = 2'd1;
    step;
    chk(xcvr_cal_en == 2'b01 && !xcvr_rx_rst, "R2 boot cal", {xcvr_cal_en, xcvr_rx_rst}, 3'b010);
    step;
    chk(xcvr_rx_rst && xcvr_cal_en == 2'b01, "R3 boot rst", {xcvr_rx_rst, xcvr_cal_en}, 3'b101);
    sys_stat = 2'd3;
    step;
    chk(done && !busy && !xcvr_rx_rst, "R2 boot end", {done, busy, xcvr_rx_rst}, 3'b100);
    step;

    for (int i = 0; i < 4; i++) run_change(VEC[i]);

    cmd_valid = 1'b1; cmd_rate = {3'd2, 3'd1}; cmd_auto = '0; cmd_pam4 = '0;
    step;
    cmd_valid = 1'b0;
    xcvr_rate_done = 2'b10;
    step;
    xcvr_rate_done = 2'b11;
    cmd_valid = 1'b1; cmd_rate = {3'd6, 3'd6};
    step;
    cmd_valid = 1'b0;
    chk(xcvr_rate_tgt == {3'd2, 3'd1}, "R12 tgt kept", 32'(xcvr_rate_tgt), 32'({3'd2, 3'd1}));
    xcvr_rate_stat = {3'd2, 3'd1};
    step;
    chk(done && !busy, "R12 finish", {done, busy}, 2'b10);
    step;
    chk(!xcvr_rate_req && !busy, "R12 no queue", {xcvr_rate_req, busy}, 2'b00);

    cmd_valid = 1'b1; cmd_rate = {3'd3, 3'd3};
    step;
    cmd_valid = 1'b0;
    repeat (TMO + 8) step;
    chk(err && !busy && !xcvr_rate_req, "R10 timeout", {err, busy, xcvr_rate_req}, 3'b100);
    cmd_valid = 1'b1;
    step;
    cmd_valid = 1'b0;
    step;
    chk(err && !xcvr_rate_req && !busy, "R10 sticky", {err, xcvr_rate_req, busy}, 3'b100);

    rst_n = 1'b0; boot_cal_mask = 2'b00; sys_stat = 2'd0;
    step;
    chk(!err && xcvr_reset_all, "R10 cleared", {err, xcvr_reset_all}, 2'b01);
    rst_n = 1'b1;
    repeat (8) step;
    sys_stat = 2'd1;
    step;
    chk(done && !busy && xcvr_cal_en == 2'b00, "R2 no cal", {done, busy, xcvr_cal_en}, 4'b1000);
    finish_run;
  end
endmodule